// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Slice with Mode Select

This block is a purely combinational 4-bit arithmetic/logic slice. Two 4-bit operands enter together with a 4-bit function code and a mode bit. The mode bit chooses between a logic bank and an arithmetic bank, each with 16 functions. In logic mode every result bit is an independent two-input Boolean function of the matching operand bits. In arithmetic mode the slice adds two operand terms, both picked by the function code, plus a carry.

The carry input and carry output are active-low. Two active-low group outputs, generate and propagate, let a separate lookahead carry unit combine several slices. An equality flag reports operand equality when the slice runs its subtract-minus-one function.

Top module: `alu_slice4`

## Requirements
- R1: With `logic_mode`=1, each result bit i equals `func_sel[2*op_a[i] + op_b[i]]`. The function code is the truth table of the bit function, so for example code 4'b0110 gives XOR and code 4'b1000 gives AND.
- R2: With `logic_mode`=1, `carry_out_n`, `grp_prop_n` and `grp_gen_n` are all 1, and `carry_in_n` has no effect on any output.
- R3: With `logic_mode`=0, `result` = (X + Y + c) mod 16, where c = NOT `carry_in_n`.
  - X is chosen by `func_sel[3:2]`: 00 gives A, 01 gives A AND B, 10 gives A OR B, 11 gives NOT A.
  - Y is chosen by `func_sel[1:0]`: 00 gives 0, 01 gives B, 10 gives NOT B, 11 gives A.
- R4: The named arithmetic codes are: 4'b0001 is A plus B plus c, 4'b0010 is A minus B minus 1 plus c, and 4'b0011 is A doubled plus c.
- R5: With `logic_mode`=0, `carry_out_n` is 0 exactly when X + Y + c is at least 16.
- R6: With `logic_mode`=0, `grp_gen_n` is 0 exactly when X + Y is at least 16, whatever the value of `carry_in_n`.
- R7: With `logic_mode`=0, `grp_prop_n` is 0 exactly when X + Y equals 15, meaning the slice would pass an incoming carry through all four bits.
- R8: `a_eq_b` is 1 exactly when `logic_mode`=0, `func_sel`=4'b0010 and `result`=4'b1111. With `carry_in_n`=1, this means the two operands are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | First operand A |
| op_b | input | 4 | Second operand B |
| func_sel | input | 4 | Function code within the current mode |
| logic_mode | input | 1 | 1 selects the logic bank, 0 selects the arithmetic bank |
| carry_in_n | input | 1 | Carry input, active-low |
| result | output | 4 | Function result |
| carry_out_n | output | 1 | Carry output, active-low |
| grp_prop_n | output | 1 | Group propagate, active-low |
| grp_gen_n | output | 1 | Group generate, active-low |
| a_eq_b | output | 1 | Equality flag |

## Verification
The whole input space is swept, 16384 combinations, so every arithmetic operand pairing and every logic truth table is seen with both carry values.

- The carry-on versus carry-off pairs separate the carry output from the group generate output.
- Operand sums of exactly 15 and exactly 16 separate propagate from generate.

Directed cases check the named operations with hand-worked values:
- addition that wraps to zero;
- subtraction with a borrow-free carry;
- doubling;
- the equality flag for equal operands under the subtract code, and its absence under the same code in logic mode.

Seeded random patterns then recheck a sample against the bench model.

// File: rtl/alu_slice4.sv
module alu_slice4 (
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  input  logic [3:0] func_sel,
  input  logic       logic_mode,
  input  logic       carry_in_n,
  output logic [3:0] result,
  output logic       carry_out_n,
  output logic       grp_prop_n,
  output logic       grp_gen_n,
  output logic       a_eq_b
);
  logic [3:0] x_term, y_term, bit_gen, bit_prop, logic_res;
  logic [4:0] arith_sum;
  logic       carry_in, grp_gen, grp_prop;

  assign carry_in = ~carry_in_n;

  always_comb begin
    unique case (func_sel[3:2])
      2'b00: x_term = op_a;
      2'b01: x_term = op_a & op_b;
      2'b10: x_term = op_a | op_b;
      default: x_term = ~op_a;
    endcase
    unique case (func_sel[1:0])
      2'b00: y_term = 4'b0000;
      2'b01: y_term = op_b;
      2'b10: y_term = ~op_b;
      default: y_term = op_a;
    endcase
  end

  assign arith_sum = {1'b0, x_term} + {1'b0, y_term} + {4'b0000, carry_in};

  assign bit_gen  = x_term & y_term;
  assign bit_prop = x_term ^ y_term;
  assign grp_gen  = bit_gen[3] | (bit_prop[3] & bit_gen[2])
                  | (bit_prop[3] & bit_prop[2] & bit_gen[1])
                  | (bit_prop[3] & bit_prop[2] & bit_prop[1] & bit_gen[0]);
  assign grp_prop = &bit_prop;

  always_comb
    for (int i = 0; i < 4; i++)
      logic_res[i] = func_sel[{op_a[i], op_b[i]}];

  assign result      = logic_mode ? logic_res : arith_sum[3:0];
  assign carry_out_n = logic_mode | ~arith_sum[4];
  assign grp_gen_n   = logic_mode | ~grp_gen;
  assign grp_prop_n  = logic_mode | ~grp_prop;
  assign a_eq_b      = ~logic_mode && (func_sel == 4'b0010) && (&result);
endmodule

module alu_slice4_chk (
  input logic [3:0] op_a,
  input logic [3:0] op_b,
  input logic [3:0] func_sel,
  input logic       logic_mode,
  input logic       carry_in_n,
  input logic [3:0] result,
  input logic       carry_out_n,
  input logic       grp_prop_n,
  input logic       grp_gen_n,
  input logic       a_eq_b
);
  always_comb begin
    // R2
    if (logic_mode) logic_flags_idle_chk: assert (carry_out_n && grp_prop_n && grp_gen_n);
    // R5
    if (!logic_mode) lookahead_carry_chk: assert (carry_out_n == ~(~grp_gen_n | (~grp_prop_n & ~carry_in_n)));
    // R7
    prop_gen_exclusive_chk: assert (grp_prop_n | grp_gen_n);
    // R8
    if (a_eq_b) eq_only_on_sub_chk: assert (!logic_mode && func_sel == 4'b0010 && result == 4'hF);
    // R1
    if (logic_mode && func_sel == 4'b0110) logic_xor_chk: assert (result == (op_a ^ op_b));
    // R4
    if (!logic_mode && func_sel == 4'b0010 && carry_in_n && op_a == op_b) sub_equal_chk: assert (a_eq_b);
  end
endmodule

bind alu_slice4 alu_slice4_chk u_alu_slice4_chk (.*);

// File: tb/alu_slice4_bench.sv
module alu_slice4_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] op_a, op_b, func_sel, result;
  logic logic_mode, carry_in_n, carry_out_n, grp_prop_n, grp_gen_n, a_eq_b;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  alu_slice4 u_alu_slice4 (.*);

  typedef struct packed {
    logic [3:0] res;
    logic cout_n, p_n, g_n, eq;
  } exp_t;

  function automatic exp_t model(input logic [3:0] a, input logic [3:0] b,
                                 input logic [3:0] s, input logic m, input logic cn);
    exp_t e;
    int x, y, c;
    if (m) begin
      for (int i = 0; i < 4; i++) e.res[i] = s[2*a[i] + b[i]];
      e.cout_n = 1'b1; e.p_n = 1'b1; e.g_n = 1'b1;
    end else begin
      case (s[3:2])
        2'd0: x = a;
        2'd1: x = a & b;
        2'd2: x = a | b;
        default: x = 15 - a;
      endcase
      case (s[1:0])
        2'd0: y = 0;
        2'd1: y = b;
        2'd2: y = 15 - b;
        default: y = a;
      endcase
      c = cn ? 0 : 1;
      e.res    = 4'((x + y + c) % 16);
      e.cout_n = !((x + y + c) >= 16);
      e.g_n    = !((x + y) >= 16);
      e.p_n    = !((x + y) == 15);
    end
    e.eq = !m && s == 4'b0010 && e.res == 4'hF;
    return e;
  endfunction

  task automatic cmp(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h s=%h m=%b cn=%b actual=%h expected=%h",
               tag, op_a, op_b, func_sel, logic_mode, carry_in_n, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                       input logic m, input logic cn);
    @(posedge clk);
    op_a = a; op_b = b; func_sel = s; logic_mode = m; carry_in_n = cn;
    @(negedge clk);
  endtask

  task automatic check_model(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                             input logic m, input logic cn);
    exp_t e;
    apply(a, b, s, m, cn);
    e = model(a, b, s, m, cn);
    if (m) begin
      cmp("R1 result", result, e.res);
      cmp("R2 flags", {1'b0, carry_out_n, grp_prop_n, grp_gen_n}, {1'b0, e.cout_n, e.p_n, e.g_n});
    end else begin
      cmp("R3 result", result, e.res);
      cmp("R5 carry_out_n", {3'b0, carry_out_n}, {3'b0, e.cout_n});
      cmp("R6 grp_gen_n", {3'b0, grp_gen_n}, {3'b0, e.g_n});
      cmp("R7 grp_prop_n", {3'b0, grp_prop_n}, {3'b0, e.p_n});
    end
    cmp("R8 a_eq_b", {3'b0, a_eq_b}, {3'b0, e.eq});
  endtask

  task automatic directed(input string tag, input logic [3:0] a, input logic [3:0] b,
                          input logic [3:0] s, input logic m, input logic cn,
                          input logic [3:0] xr, input logic [3:0] xflags);
    apply(a, b, s, m, cn);
    cmp(tag, result, xr);
    cmp(tag, {carry_out_n, grp_gen_n, grp_prop_n, a_eq_b}, xflags);
  endtask

  initial begin
    int unsigned seed_word;
    op_a = '0; op_b = '0; func_sel = '0; logic_mode = 1'b0; carry_in_n = 1'b1;
    seed_word = $urandom(32'd7321);

    // Idle inputs: A=0, Y=0, no carry.
    directed("R3 idle", 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 4'h0, 4'b1110);
    // R4 add wrapping: 7+9 = 16
    directed("R4 add", 4'h7, 4'h9, 4'b0001, 1'b0, 1'b1, 4'h0, 4'b0010);
    // R4 subtract: 9+11+1 = 21
    directed("R4 sub", 4'h9, 4'h4, 4'b0010, 1'b0, 1'b0, 4'h5, 4'b0010);
    // R4 doubling: 12+12 = 24
    directed("R4 double", 4'hC, 4'h0, 4'b0011, 1'b0, 1'b1, 4'h8, 4'b0010);
    // R8 equal operands under subtract code
    directed("R8 equal", 4'h6, 4'h6, 4'b0010, 1'b0, 1'b1, 4'hF, 4'b1101);
    // R1 XOR code 0110
    directed("R1 xor", 4'hC, 4'hA, 4'b0110, 1'b1, 1'b0, 4'h6, 4'b1110);
    // R2 / R8 logic mode with subtract code: no equality, carry ignored
    directed("R2 logic sub code", 4'h5, 4'h5, 4'b0010, 1'b1, 1'b0, 4'h0, 4'b1110);
    directed("R2 logic sub code cn", 4'h5, 4'h5, 4'b0010, 1'b1, 1'b1, 4'h0, 4'b1110);

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++)
              check_model(4'(a), 4'(b), 4'(s), 1'(m), 1'(c));

    for (int k = 0; k < 2000; k++)
      check_model(4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule